// File: doc/BRIEF.md
# Fixed-Slot Code Block Cache

This instruction cache holds whole code blocks, such as a function or a fragment of one, instead of individual lines. Storage is split into equal slots, and every block occupies exactly one slot. Any words of a slot beyond the block's length stay unused. The cache consults its tags only when the core reports a call or a return. That event carries the base word address of the target block and the block's length in words. Between events the core reads instructions by giving a word offset into the current block, and the cache answers from the current slot in the same cycle. These reads always hit and change no state.

On an event that misses, the cache chooses the least recently used slot and invalidates it. It then streams the block in from memory as a series of fixed-length burst reads. The slot becomes valid, and becomes the current slot, only after the last word of the last burst has arrived. Stall stays high from the missing event until that point. Memory requests use a valid/ready stream. The cache holds a request and its address steady until memory accepts it. It raises its response ready only while it waits for the words of an accepted burst, and memory may leave gaps between response words. Calls and returns presented while stall is high are ignored.

Top module: `method_cache`

## Requirements
- R1: After reset, stall, mem_req_valid and mem_rsp_ready are low and every slot is invalid, so the first event always misses.
- R2: An event whose base address matches a valid slot keeps stall low, causes no memory request, and from the next cycle fetches read that block.
- R3: An event that misses raises stall in the same cycle. Stall stays high until the block is loaded. The cache issues ceil(size/8) burst requests with addresses base, base+8, base+16, ... in that order.
- R4: While mem_req_valid is high and mem_req_ready is low, the request stays valid on the next cycle with an unchanged address.
- R5: mem_rsp_ready is high only after a request has been accepted and never together with mem_req_valid. Word k of burst b is stored at slot offset 8*b+k, so fetch offset n returns memory word base+n.
- R6: fetch_data shows the word at fetch_offset of the current block in the same cycle. Fetches change no cache state, so they never alter a later event's hit or miss outcome.
- R7: Four distinct blocks can be resident at once. Each event, hit or miss, makes its block most recently used. A miss with all slots valid evicts the block whose last event is oldest.
- R8: An event presented while stall is high is ignored. It changes neither the fill in progress nor residency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | Call or return event |
| evt_base | input | ADDR_W | Base word address of the target block |
| evt_size | input | OFF_W+1 | Block length in words, 1 to SLOT_WORDS |
| stall | output | 1 | Core must wait; target block not yet resident |
| fetch_offset | input | OFF_W | Word offset into the current block |
| fetch_data | output | DATA_W | Instruction word at fetch_offset |
| mem_req_valid | output | 1 | Burst read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | First word address of the burst |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_ready | output | 1 | Cache accepts response words |
| mem_rsp_data | input | DATA_W | Response word |

## Verification
The lookup of a new event can land in the same cycle as the last word of a fill completing. The core then releases the event one cycle after stall falls. The bench also drives a second event into the middle of a fill, so that the event path and the burst path are active together. It judges the result by the addresses of the bursts memory saw, and by whether a later event on the intruding block misses against a least-recently-used model kept in the bench. A sweep over blocks of lengths 1, 8, 9, 17, 33, 40 and 64 checks fetched words against an arithmetic memory pattern.

// File: rtl/mcache_pkg.sv
package mcache_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_REQ  = 2'd1,
    FILL_DATA = 2'd2
  } fill_state_t;
endpackage

// File: rtl/mcache_lru.sv
module mcache_lru #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_en,
  input  logic [SLOT_W-1:0] touch_slot,
  output logic [SLOT_W-1:0] victim
);
  // age 0 = most recent, SLOTS-1 = oldest
  logic [SLOT_W-1:0] age [SLOTS];
  logic [SLOT_W-1:0] touched_age;

  assign touched_age = age[touch_slot];

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          age[i] <= SLOT_W'(SLOTS - 1 - i);
        end else if (touch_en) begin
          if (touch_slot == SLOT_W'(i))
            age[i] <= '0;
          else if (age[i] < touched_age)
            age[i] <= age[i] + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    victim = '0;
    for (int i = 0; i < SLOTS; i++)
      if (age[i] == SLOT_W'(SLOTS - 1))
        victim = SLOT_W'(i);
  end
endmodule

// File: rtl/mcache_tags.sv
module mcache_tags #(
  parameter int SLOTS  = 4,
  parameter int ADDR_W = 32,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_base,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  input  logic              alloc_en,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic              fill_done,
  input  logic [SLOT_W-1:0] done_slot
);
  logic [ADDR_W-1:0] tag   [SLOTS];
  logic [SLOTS-1:0]  valid;
  logic [SLOTS-1:0]  match;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid[i] <= 1'b0;
          tag[i]   <= '0;
        end else if (alloc_en && alloc_slot == SLOT_W'(i)) begin
          valid[i] <= 1'b0;
          tag[i]   <= look_base;
        end else if (fill_done && done_slot == SLOT_W'(i)) begin
          valid[i] <= 1'b1;
        end
      end
      assign match[i] = valid[i] && (tag[i] == look_base);
    end
  endgenerate

  assign hit = |match;

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < SLOTS; i++)
      if (match[i]) hit_slot = SLOT_W'(i);
  end
endmodule

// File: rtl/mcache_store.sv
module mcache_store #(
  parameter int SLOTS      = 4,
  parameter int SLOT_WORDS = 64,
  parameter int DATA_W     = 32,
  parameter int SLOT_W     = $clog2(SLOTS),
  parameter int OFF_W      = $clog2(SLOT_WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = SLOTS * SLOT_WORDS;
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[{wr_slot, wr_off}] <= wr_data;
  end

  assign rd_data = words[{rd_slot, rd_off}];
endmodule

// File: rtl/mcache_fill.sv
module mcache_fill
  import mcache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SLOTS       = 4,
  parameter int SLOT_WORDS  = 64,
  parameter int BURST_WORDS = 8,
  parameter int SLOT_W      = $clog2(SLOTS),
  parameter int OFF_W       = $clog2(SLOT_WORDS),
  parameter int SIZE_W      = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [SIZE_W-1:0] start_size,
  input  logic [SLOT_W-1:0] start_slot,
  output logic              busy,
  output logic              done,
  output logic [SLOT_W-1:0] fill_slot,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              wr_en,
  output logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_data
);
  localparam int BW_W   = $clog2(BURST_WORDS);
  localparam int BIDX_W = OFF_W - BW_W;

  fill_state_t       state;
  logic [ADDR_W-1:0] base_q;
  logic [BIDX_W-1:0] bidx, last_q;
  logic [BW_W-1:0]   widx;
  logic [SIZE_W-1:0] size_m1;
  logic              word_ok, burst_end, last_burst;

  assign size_m1    = start_size - 1'b1;
  assign busy       = (state != FILL_IDLE);
  assign fill_slot  = start_slot_q;
  assign mem_req_valid = (state == FILL_REQ);
  assign mem_req_addr  = base_q + {{(ADDR_W-OFF_W){1'b0}}, bidx, {BW_W{1'b0}}};
  assign mem_rsp_ready = (state == FILL_DATA);
  assign word_ok    = mem_rsp_ready && mem_rsp_valid;
  assign burst_end  = word_ok && (widx == BW_W'(BURST_WORDS - 1));
  assign last_burst = (bidx == last_q);
  assign done       = burst_end && last_burst;
  assign wr_en      = word_ok;
  assign wr_off     = {bidx, widx};
  assign wr_data    = mem_rsp_data;

  logic [SLOT_W-1:0] start_slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= FILL_IDLE;
      base_q       <= '0;
      bidx         <= '0;
      last_q       <= '0;
      widx         <= '0;
      start_slot_q <= '0;
    end else begin
      case (state)
        FILL_IDLE: if (start) begin
          base_q       <= start_base;
          last_q       <= size_m1[OFF_W-1:BW_W];
          bidx         <= '0;
          start_slot_q <= start_slot;
          state        <= FILL_REQ;
        end
        FILL_REQ: if (mem_req_ready) begin
          widx  <= '0;
          state <= FILL_DATA;
        end
        FILL_DATA: if (word_ok) begin
          widx <= widx + 1'b1;
          if (burst_end) begin
            if (last_burst) begin
              state <= FILL_IDLE;
            end else begin
              bidx  <= bidx + 1'b1;
              state <= FILL_REQ;
            end
          end
        end
        default: state <= FILL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/method_cache.sv
module method_cache #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SLOTS       = 4,
  parameter int SLOT_WORDS  = 64,
  parameter int BURST_WORDS = 8,
  parameter int OFF_W       = $clog2(SLOT_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_base,
  input  logic [OFF_W:0]    evt_size,
  output logic              stall,
  input  logic [OFF_W-1:0]  fetch_offset,
  output logic [DATA_W-1:0] fetch_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic              busy, lookup, hit, miss, done;
  logic [SLOT_W-1:0] hit_slot, victim, fill_slot, cur_slot, touch_slot;
  logic              wr_en;
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] wr_data;

  assign lookup     = evt_valid && !busy;
  assign miss       = lookup && !hit;
  assign stall      = busy || miss;
  assign touch_slot = hit ? hit_slot : victim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cur_slot <= '0;
    else if (lookup && hit)    cur_slot <= hit_slot;
    else if (done)             cur_slot <= fill_slot;
  end

  mcache_tags #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .look_base(evt_base),
    .hit(hit), .hit_slot(hit_slot),
    .alloc_en(miss), .alloc_slot(victim),
    .fill_done(done), .done_slot(fill_slot)
  );

  mcache_lru #(.SLOTS(SLOTS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(lookup),
    .touch_slot(touch_slot), .victim(victim)
  );

  mcache_fill #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS),
    .SLOT_WORDS(SLOT_WORDS), .BURST_WORDS(BURST_WORDS)
  ) u_fill (
    .clk(clk), .rst_n(rst_n),
    .start(miss), .start_base(evt_base), .start_size(evt_size), .start_slot(victim),
    .busy(busy), .done(done), .fill_slot(fill_slot),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data)
  );

  mcache_store #(
    .SLOTS(SLOTS), .SLOT_WORDS(SLOT_WORDS), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .wr_en(wr_en), .wr_slot(fill_slot), .wr_off(wr_off), .wr_data(wr_data),
    .rd_slot(cur_slot), .rd_off(fetch_offset), .rd_data(fetch_data)
  );
endmodule

// File: rtl/mcache_chk.sv
module mcache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              stall,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_ready
);
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  a_r3_stall_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready) |-> stall);

  a_r3_miss_requests: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && stall && !mem_req_valid && !mem_rsp_ready |=> mem_req_valid);

  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !stall |=> !mem_req_valid && !mem_rsp_ready);
endmodule

bind method_cache mcache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .stall(stall),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_ready(mem_rsp_ready)
);

// File: tb/method_cache_tb.sv
module method_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 6;
  localparam int LAT    = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              evt_valid = 1'b0;
  logic [ADDR_W-1:0] evt_base = '0;
  logic [OFF_W:0]    evt_size = 7'd1;
  logic              stall;
  logic [OFF_W-1:0]  fetch_offset = '0;
  logic [DATA_W-1:0] fetch_data;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic              mem_rsp_ready;
  logic [DATA_W-1:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [ADDR_W-1:0] req_log [4096];
  int nlog = 0;

  logic [ADDR_W-1:0] lru_list [4];
  int lru_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  method_cache u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_base(evt_base),
    .evt_size(evt_size), .stall(stall), .fetch_offset(fetch_offset),
    .fetch_data(fetch_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [DATA_W-1:0] memw(input logic [ADDR_W-1:0] a);
    return (a * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [ADDR_W-1:0] blk_base(input int j);
    return ADDR_W'(32'h100 * j + 5 * j + 3);
  endfunction

  function automatic int blk_size(input int j);
    case (j)
      0: return 1;
      1: return 8;
      2: return 9;
      3: return 17;
      4: return 64;
      5: return 33;
      default: return 40;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk)
    if (mem_req_valid && mem_req_ready) begin
      req_log[nlog] <= mem_req_addr;
      nlog <= nlog + 1;
    end

  // memory model: valid/ready request, fixed latency, occasional gap
  initial begin
    int nreq = 0;
    logic [ADDR_W-1:0] a;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        a = mem_req_addr;
        for (int d = 0; d < nreq % 3; d++) begin
          chk(mem_rsp_ready == 1'b0, "R5 rsp_ready before accept", 64'(mem_rsp_ready), 0);
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == a, "R4 request held", 64'(mem_req_addr), 64'(a));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          if (k == 3 && nreq % 2 == 1) begin
            mem_rsp_valid = 1'b0;
            @(negedge clk);
          end
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memw(a + ADDR_W'(k));
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        nreq++;
      end
    end
  end

  function automatic int model_find(input logic [ADDR_W-1:0] b);
    for (int i = 0; i < lru_n; i++) if (lru_list[i] == b) return i;
    return -1;
  endfunction

  task automatic model_touch(input logic [ADDR_W-1:0] b);
    int p;
    p = model_find(b);
    if (p < 0) begin
      if (lru_n < 4) lru_n++;
      p = lru_n - 1;
    end
    for (int i = p; i > 0; i--) lru_list[i] = lru_list[i-1];
    lru_list[0] = b;
  endtask

  task automatic do_event(input int j, input bit intrude);
    logic [ADDR_W-1:0] b;
    int sz, start, nb, off;
    bit exp_hit;
    b  = blk_base(j);
    sz = blk_size(j);
    exp_hit = (model_find(b) >= 0);
    @(negedge clk);
    start = nlog;
    evt_valid = 1'b1;
    evt_base  = b;
    evt_size  = 7'(sz);
    #1;
    if (exp_hit) chk(stall == 1'b0, "R2/R7 hit keeps stall low", 64'(stall), 0);
    else         chk(stall == 1'b1, "R3/R7 miss raises stall", 64'(stall), 1);
    @(negedge clk);
    evt_valid = 1'b0;
    if (intrude && !exp_hit && j != 6) begin
      evt_valid = 1'b1;
      evt_base  = blk_base(6);
      evt_size  = 7'(blk_size(6));
      @(negedge clk);
      evt_valid = 1'b0;
    end
    while (stall) @(negedge clk);
    nb = exp_hit ? 0 : (sz + 7) / 8;
    chk(nlog - start == nb, "R3 burst count", 64'(nlog - start), 64'(nb));
    for (int k = 0; k < nb && k < nlog - start; k++)
      chk(req_log[start + k] == b + ADDR_W'(8 * k), "R3 burst address order",
          64'(req_log[start + k]), 64'(b + ADDR_W'(8 * k)));
    model_touch(b);
    for (int t = 0; t < ((j == 4) ? 64 : 3); t++) begin
      off = (j == 4) ? t : (t == 0 ? 0 : (t == 1 ? sz - 1 : sz / 2));
      fetch_offset = OFF_W'(off);
      #1;
      chk(fetch_data == memw(b + ADDR_W'(off)), "R5/R6 fetched word",
          64'(fetch_data), 64'(memw(b + ADDR_W'(off))));
      @(negedge clk);
    end
    chk(!stall && !mem_req_valid, "R6 fetch leaves cache idle", 64'({stall, mem_req_valid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(stall == 1'b0, "R1 stall after reset", 64'(stall), 0);
    chk(mem_req_valid == 1'b0, "R1 no request after reset", 64'(mem_req_valid), 0);
    chk(mem_rsp_ready == 1'b0, "R1 rsp_ready after reset", 64'(mem_rsp_ready), 0);
    // R7 LRU scenario: four fill, refresh 0, then evictions in age order
    do_event(0, 0); do_event(1, 0); do_event(2, 0); do_event(3, 0);
    do_event(0, 0);
    do_event(4, 0);
    do_event(1, 0);
    do_event(0, 0);
    do_event(3, 0);
    // R8 intruding event during fill, later hit/miss judged by model
    do_event(5, 1);
    do_event(6, 0);
    // sweep
    for (int k = 0; k < 60; k++)
      do_event((k * k * 3 + k) % 7, (k % 5) == 2);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule